// File: doc/BRIEF.md
# Fractional Microsecond Tick Counter

This block turns a reference oscillator clock into a steady one-microsecond tick enable. It does not use an integer divider. An accumulator adds a programmable numerator M on every oscillator cycle. Each time the sum reaches the denominator N, the accumulator subtracts N and emits a tick. Because of this, oscillators such as 19.2 MHz still give exactly one tick per microsecond on average.

Every tick also advances a free-running microsecond counter. The tick itself is offered as an enable to the timer channels. Software reads the counter and reads or writes the ratio register through a small register port. The ratio register loads a default chosen by a 2-bit oscillator-frequency code while reset is asserted.

Top module: `usec_tick_counter`

## Requirements
- R1: The ratio register sits at byte offset 0x4. Bits 15:8 hold M−1 and bits 7:0 hold N−1. A write sets both fields. Bits 31:16 of a write are dropped and always read back as zero.
- R2: While reset is high, the ratio register loads a default from `osc_code`:
  - 0 gives M=1, N=13 (read value 0x000C).
  - 1 gives M=5, N=96 (0x045F).
  - 2 gives M=1, N=12 (0x000B).
  - 3 gives M=1, N=26 (0x0019).
- R3: For M ≤ N, over any N×K clock cycles counted from reset release or from a ratio write, `tick_o` is high in exactly M×K cycles.
- R4: With M=1, the first tick appears on the N-th clock edge after reset release or after a ratio write.
- R5: A ratio write clears the accumulator. `tick_o` is low right after the write edge, even where a tick was due.
- R6: The counter reads at offset 0x0. It rises by one on the edge after each cycle in which `tick_o` is high, and otherwise holds.
- R7: The counter is zero after reset and wraps from all ones to zero.
- R8: Writes to offset 0x0 or to unmapped offsets change neither the counter nor the ratio register.
- R9: When M ≥ N, `tick_o` is high on every cycle after the first edge following reset or a ratio write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference oscillator clock |
| rst | input | 1 | Synchronous active-high reset |
| osc_code | input | 2 | Oscillator frequency code selecting the reset ratio |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| tick_o | output | 1 | Microsecond tick enable for timer channels |

## Verification
A wrong accumulator remainder shows up at the ports as a tick count over an N×K window that is off by at least one. It also shifts the first tick away from edge N, so the error is visible within one ratio period. A counter fault shows in the read value on the edge after the next tick. A bad reset default shows immediately as the wrong ratio read back after reset.

// File: rtl/usec_tick_pkg.sv
package usec_tick_pkg;

    localparam int FIELD_W = 8;
    localparam int BUS_W   = 32;
    localparam int ACC_W   = FIELD_W + 2;
    localparam int OFS_COUNT = 0;
    localparam int OFS_RATIO = 4;

    typedef struct packed {
        logic [FIELD_W-1:0] m_m1;
        logic [FIELD_W-1:0] n_m1;
    } ratio_t;

    function automatic ratio_t ratio_for_osc(input logic [1:0] code);
        ratio_t r;
        case (code)
            2'd0:    r = '{m_m1: 8'd0, n_m1: 8'd12};
            2'd1:    r = '{m_m1: 8'd4, n_m1: 8'd95};
            2'd2:    r = '{m_m1: 8'd0, n_m1: 8'd11};
            default: r = '{m_m1: 8'd0, n_m1: 8'd25};
        endcase
        return r;
    endfunction

endpackage

// File: rtl/usec_tick_ratio_reg.sv
module usec_tick_ratio_reg
    import usec_tick_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           osc_code,
    input  logic                 wr,
    input  logic [2*FIELD_W-1:0] wdata,
    output ratio_t               ratio_q
);

    always_ff @(posedge clk) begin
        if (rst)
            ratio_q <= ratio_for_osc(osc_code);
        else if (wr)
            ratio_q <= ratio_t'(wdata);
    end

    // R8: ratio only moves on a decoded write
    a_r8_ratio_hold: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ratio_q));

endmodule

// File: rtl/usec_tick_accum.sv
module usec_tick_accum
    import usec_tick_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   clr,
    input  ratio_t ratio,
    output logic   tick_q
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] m_v;
    logic [ACC_W-1:0] n_v;
    logic [ACC_W-1:0] sum;

    always_comb begin
        m_v = ACC_W'(ratio.m_m1) + ACC_W'(1);
        n_v = ACC_W'(ratio.n_m1) + ACC_W'(1);
        sum = acc_q + m_v;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else if (m_v >= n_v) begin
            acc_q  <= '0;
            tick_q <= 1'b1;
        end else if (sum >= n_v) begin
            acc_q  <= sum - n_v;
            tick_q <= 1'b1;
        end else begin
            acc_q  <= sum;
            tick_q <= 1'b0;
        end
    end

    // R3: remainder stays below the divisor
    a_r3_acc_below_n: assert property (@(posedge clk) disable iff (rst)
        (!clr && m_v < n_v) |=> acc_q < $past(n_v));

    // R5: clearing suppresses the tick
    a_r5_clear_no_tick: assert property (@(posedge clk) disable iff (rst)
        clr |=> !tick_q);

    // R9: ratio at or above one ticks every cycle
    a_r9_saturate: assert property (@(posedge clk) disable iff (rst)
        (!clr && m_v >= n_v) |=> tick_q);

endmodule

// File: rtl/usec_tick_count.sv
module usec_tick_count #(
    parameter int COUNT_W = 32
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               inc,
    output logic [COUNT_W-1:0] count_q
);

    always_ff @(posedge clk) begin
        if (rst)
            count_q <= '0;
        else if (inc)
            count_q <= count_q + COUNT_W'(1);
    end

    // R6: one step per tick
    a_r6_step: assert property (@(posedge clk) disable iff (rst)
        inc |=> count_q == $past(count_q) + COUNT_W'(1));

    // R6: hold without a tick
    a_r6_hold: assert property (@(posedge clk) disable iff (rst)
        !inc |=> $stable(count_q));

endmodule

// File: rtl/usec_tick_counter.sv
module usec_tick_counter
    import usec_tick_pkg::*;
#(
    parameter int COUNT_W = 32,
    parameter int ADDR_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        osc_code,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output logic [BUS_W-1:0]  bus_rdata,
    output logic              tick_o
);

    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_RATIO = ADDR_W'(OFS_RATIO);

    ratio_t             ratio;
    logic               ratio_wr;
    logic               tick;
    logic [COUNT_W-1:0] count;

    assign ratio_wr = bus_wr && (bus_addr == A_RATIO);

    usec_tick_ratio_reg u_ratio (
        .clk      (clk),
        .rst      (rst),
        .osc_code (osc_code),
        .wr       (ratio_wr),
        .wdata    (bus_wdata[2*FIELD_W-1:0]),
        .ratio_q  (ratio)
    );

    usec_tick_accum u_accum (
        .clk    (clk),
        .rst    (rst),
        .clr    (ratio_wr),
        .ratio  (ratio),
        .tick_q (tick)
    );

    usec_tick_count #(.COUNT_W(COUNT_W)) u_count (
        .clk     (clk),
        .rst     (rst),
        .inc     (tick),
        .count_q (count)
    );

    assign tick_o = tick;

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_COUNT)
            bus_rdata = BUS_W'(count);
        else if (bus_addr == A_RATIO)
            bus_rdata = BUS_W'(ratio);
    end

endmodule

// File: tb/usec_tick_counter_test.sv
module usec_tick_counter_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  osc_code = 2'd0;
    logic [3:0]  bus_addr = 4'd0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = 32'd0;
    logic [31:0] bus_rdata;
    logic [31:0] bus_rdata_w;
    logic        tick_o;
    logic        tick_w;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    usec_tick_counter uut (
        .clk(clk), .rst(rst), .osc_code(osc_code), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tick_o(tick_o)
    );

    usec_tick_counter #(.COUNT_W(8)) uut_w (
        .clk(clk), .rst(rst), .osc_code(osc_code), .bus_addr(bus_addr),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata_w),
        .tick_o(tick_w)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic [1:0] code);
        @(negedge clk);
        osc_code = code;
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d, output logic [31:0] dw);
        bus_addr = a;
        #1;
        d  = bus_rdata;
        dw = bus_rdata_w;
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic run(input int edges, output int ticks, output int first);
        ticks = 0;
        first = -1;
        for (int i = 1; i <= edges; i++) begin
            @(negedge clk);
            if (tick_o) begin
                ticks++;
                if (first < 0) first = i;
            end
        end
    endtask

    initial begin
        int          em [4] = '{1, 5, 1, 1};
        int          en [4] = '{13, 96, 12, 26};
        int          cm [4] = '{3, 2, 5, 7};
        int          cn [4] = '{7, 256, 5, 3};
        int          ck [4] = '{4, 1, 2, 2};
        int          ticks, first, exp_t;
        logic [31:0] d, dw, c0, w0;

        for (int c = 0; c < 4; c++) begin
            do_reset(2'(c));
            rd(4'h0, d, dw);
            check("R7 count after reset", d, 32'd0);
            rd(4'h4, d, dw);
            check("R2 default ratio", d, 32'(((em[c] - 1) << 8) | (en[c] - 1)));
            run(en[c] * 3, ticks, first);
            check("R3 ticks per window", 32'(ticks), 32'(em[c] * 3));
            if (em[c] == 1) check("R4 first tick edge", 32'(first), 32'(en[c]));
            @(negedge clk);
            rd(4'h0, d, dw);
            check("R6 count equals ticks", d, 32'(em[c] * 3));
        end

        for (int p = 0; p < 4; p++) begin
            wr(4'h4, 32'(((cm[p] - 1) << 8) | (cn[p] - 1)));
            run(cn[p] * ck[p], ticks, first);
            exp_t = (cm[p] >= cn[p]) ? cn[p] * ck[p] : cm[p] * ck[p];
            check(cm[p] >= cn[p] ? "R9 every cycle" : "R3 custom ratio",
                  32'(ticks), 32'(exp_t));
            if (cm[p] >= cn[p]) check("R9 first edge", 32'(first), 32'd1);
        end

        wr(4'h4, 32'h0000_0009);
        run(9, ticks, first);
        check("R4 no early tick", 32'(ticks), 32'd0);
        wr(4'h4, 32'h0000_0009);
        check("R5 tick cleared by write", 32'(tick_o), 32'd0);
        run(10, ticks, first);
        check("R5 restart from zero", 32'(first), 32'd10);

        wr(4'h8, 32'h0000_FFFF);
        rd(4'h4, d, dw);
        check("R8 unmapped write ignored", d, 32'h0000_0009);
        wr(4'h4, 32'h0000_0412);
        rd(4'h4, d, dw);
        check("R1 field write", d, 32'h0000_0412);
        wr(4'h4, 32'hABCD_0000);
        rd(4'h4, d, dw);
        check("R1 upper bits dropped", d, 32'h0000_0000);

        run(3, ticks, first);
        rd(4'h0, c0, w0);
        wr(4'h0, 32'h1234_5678);
        rd(4'h0, d, dw);
        check("R8 counter not writable", d, c0 + 32'd1);

        rd(4'h0, c0, w0);
        run(300, ticks, first);
        rd(4'h0, d, dw);
        check("R6 count steady ticking", d, c0 + 32'd300);
        check("R7 narrow counter wraps", dw, (w0 + 32'd300) & 32'hFF);

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule